// File: doc/BRIEF.md
# Quad SPI Flash Boot Loader

This block copies a calibration image from an external serial NOR flash into an on-chip SRAM as soon as reset is released. It needs no start command. The engine first reads the flash's second status register to see whether quad operation is enabled. If it is not, the engine runs a short enable routine:

1. It sends write enable.
2. It writes the status register.
3. It polls until the write finishes.
4. It reads the status register again.

The engine then issues a quad-output fast read at a fixed flash address. It turns all four IO lines around to input during the dummy clocks. It then gathers four bits on every serial clock.

Nibbles are paired into bytes, with the high nibble first. Bytes are packed into SRAM-width words, with the first byte in the lowest lane. Each word is written to the next SRAM address, counting up from zero. The transfer length comes from a byte-count input. When the count is reached, chip select rises and the clock stops. If the length is not a whole number of words, the last word is written with its unused lanes cleared. A sticky done flag then rises, and the block hands the SRAM port back by dropping its select output.

The serial clock runs at half the core clock. The flash samples on the rising edge of the serial clock, and the engine samples returned data on that same edge.

Top module: `qspi_boot_loader`

## Requirements
- R1: While reset is held, and whenever no command is in flight, `flash_cs_n` is 1 and `flash_sclk` is 0. The first command after reset is the status-2 read, opcode 0x35. Every opcode is sent MSB first on IO0 and is sampled by the flash on rising `flash_sclk`.
- R2: If bit 1 (quad enable) of the status-2 byte is 1, the next command is opcode 0x6B, followed by the 24-bit address `FLASH_ADDR`, MSB first on IO0. Exactly one such read is issued.
- R3: If the quad-enable bit is 0, the engine runs the enable routine in this order:
  - write enable, opcode 0x06;
  - status-2 write, opcode 0x31, with data byte 0x02;
  - status-1 read, opcode 0x05, repeated while bit 0 (busy) is 1;
  - status-2 read again.
- R4: After the 32 command and address bits, `flash_io_oe` is 0 on all four lines before the flash starts driving. There are 8 dummy clocks. Each later rising clock captures one nibble, with IO3 as its MSB. The first nibble of each pair is the high half of the byte.
- R5: Byte k of the stream goes to lane (k mod L) of word (k div L), where L = SRAM_W/8. Each word is written once, with `sram_we_n` and `sram_ce_n` both low for exactly one clock while `sram_sel` is 1. Addresses start at 0 and rise by 1 per write.
- R6: When `total_bytes` is not a multiple of L, the final word is written with its unused upper lanes equal to 0.
- R7: Exactly `total_bytes` bytes are clocked in (40 + 2·`total_bytes` rising clocks in the read command). Chip select then rises, and no further serial clock edge occurs.
- R8: `done` rises one clock after the last write and stays 1 until reset. At the same time `sram_sel` falls to 0.
- R9: With `total_bytes` = 0, no read command is issued and no SRAM write occurs. `done` still rises after the status check.
- R10: During single-line command bits, the engine drives IO0, IO2 and IO3 with `flash_io_oe` = 4'b1101, and holds IO2 and IO3 at 1. IO1 is never driven by the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; release starts the load |
| total_bytes | input | CNT_W | Number of bytes to copy, held stable during the load |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Flash serial clock, idle low |
| flash_io_out | output | 4 | Values driven on IO3..IO0 |
| flash_io_oe | output | 4 | Per-line output enable for IO3..IO0 |
| flash_io_in | input | 4 | Values sensed on IO3..IO0 |
| sram_addr | output | SRAM_AW | SRAM word address |
| sram_wdata | output | SRAM_W | SRAM write data |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_sel | output | 1 | SRAM port mux select; 1 while the loader owns the port |
| done | output | 1 | Load complete, sticky |

## Verification
The path that is hardest to reach from the ports is the quad-enable repair loop. In that loop the status-1 poll must repeat while the flash reports busy, and the loader must then re-check status 2 before reading.

The bench's behavioural flash model can start with quad enable clear. It can also hold its busy bit for a chosen number of polls. The bench then counts every opcode the loader sends.

Odd transfer lengths are checked against zero-filled final words. The flash model also flags any cycle in which it and the loader drive the same line.

// File: rtl/qspi_boot_loader.sv
module qspi_boot_loader #(
  parameter int          SRAM_W     = 32,
  parameter int          SRAM_AW    = 10,
  parameter int          CNT_W      = 20,
  parameter logic [23:0] FLASH_ADDR = 24'h001000,
  parameter int          GAP_CLKS   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   total_bytes,
  output logic               flash_cs_n,
  output logic               flash_sclk,
  output logic [3:0]         flash_io_out,
  output logic [3:0]         flash_io_oe,
  input  logic [3:0]         flash_io_in,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [SRAM_W-1:0]  sram_wdata,
  output logic               sram_we_n,
  output logic               sram_ce_n,
  output logic               sram_sel,
  output logic               done
);
  localparam int LANES = SRAM_W / 8;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int GW    = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {ST_GAP, ST_XFER, ST_DONE} st_t;
  typedef enum logic [2:0] {OP_RDSR2, OP_WREN, OP_WRSR, OP_RDSR1, OP_READ, OP_NONE} op_t;

  st_t               st;
  op_t               op, nxt;
  logic [GW-1:0]     gap;
  logic [31:0]       sh;
  logic [5:0]        cyc;
  logic              fin, oe_q, nib_lo;
  logic [7:0]        rx;
  logic [3:0]        nhi;
  logic [SRAM_W-1:0] wbuf;
  logic [LW-1:0]     lane;
  logic [CNT_W-1:0]  nbytes;
  logic [SRAM_AW-1:0] waddr;

  function automatic logic [31:0] cmd_of(op_t o);
    case (o)
      OP_RDSR2: return {8'h35, 24'h0};
      OP_WREN:  return {8'h06, 24'h0};
      OP_WRSR:  return {8'h31, 8'h02, 16'h0};
      OP_RDSR1: return {8'h05, 24'h0};
      default:  return {8'h6B, FLASH_ADDR};
    endcase
  endfunction

  logic [7:0]        st_byte, rd_byte;
  logic [SRAM_W-1:0] wnext;
  logic              last_byte, word_full;

  assign st_byte   = {rx[6:0], flash_io_in[1]};
  assign rd_byte   = {nhi, flash_io_in};
  assign wnext     = wbuf | (SRAM_W'(rd_byte) << {lane, 3'b000});
  assign last_byte = ({1'b0, nbytes} + 1'b1) == {1'b0, total_bytes};
  assign word_full = (lane == LW'(LANES - 1));

  assign flash_io_out = {2'b11, 1'b0, sh[31]};
  assign flash_io_oe  = oe_q ? 4'b1101 : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_GAP;        op <= OP_RDSR2;   nxt <= OP_NONE;
      gap <= '0;           sh <= '0;         cyc <= '0;
      fin <= 1'b0;         oe_q <= 1'b1;     nib_lo <= 1'b0;
      rx <= '0;            nhi <= '0;        wbuf <= '0;
      lane <= '0;          nbytes <= '0;     waddr <= '0;
      flash_cs_n <= 1'b1;  flash_sclk <= 1'b0;
      sram_addr <= '0;     sram_wdata <= '0;
      sram_we_n <= 1'b1;   sram_ce_n <= 1'b1;
      sram_sel <= 1'b1;    done <= 1'b0;
    end else begin
      sram_we_n <= 1'b1;
      sram_ce_n <= 1'b1;
      case (st)
        ST_GAP: begin
          if (gap == GW'(GAP_CLKS - 1)) begin
            gap <= '0;
            st <= ST_XFER;
            flash_cs_n <= 1'b0;
            sh <= cmd_of(op);
            cyc <= '0;
            fin <= 1'b0;
            oe_q <= 1'b1;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        ST_XFER: begin
          if (!flash_sclk) begin
            flash_sclk <= 1'b1;
            if (cyc != 6'd40) cyc <= cyc + 6'd1;
            case (op)
              OP_RDSR2, OP_RDSR1: begin
                if (cyc >= 6'd8) begin
                  rx <= st_byte;
                  if (cyc == 6'd15) begin
                    fin <= 1'b1;
                    if (op == OP_RDSR2)
                      nxt <= st_byte[1] ? ((total_bytes == '0) ? OP_NONE : OP_READ) : OP_WREN;
                    else
                      nxt <= st_byte[0] ? OP_RDSR1 : OP_RDSR2;
                  end
                end
              end
              OP_WREN: if (cyc == 6'd7) begin
                fin <= 1'b1;
                nxt <= OP_WRSR;
              end
              OP_WRSR: if (cyc == 6'd15) begin
                fin <= 1'b1;
                nxt <= OP_RDSR1;
              end
              OP_READ: if (cyc == 6'd40) begin
                if (!nib_lo) begin
                  nhi <= flash_io_in;
                  nib_lo <= 1'b1;
                end else begin
                  nib_lo <= 1'b0;
                  nbytes <= nbytes + 1'b1;
                  if (word_full || last_byte) begin
                    sram_we_n <= 1'b0;
                    sram_ce_n <= 1'b0;
                    sram_addr <= waddr;
                    sram_wdata <= wnext;
                    waddr <= waddr + 1'b1;
                    wbuf <= '0;
                    lane <= '0;
                  end else begin
                    wbuf <= wnext;
                    lane <= lane + 1'b1;
                  end
                  if (last_byte) begin
                    fin <= 1'b1;
                    nxt <= OP_NONE;
                  end
                end
              end
              default: ;
            endcase
          end else begin
            flash_sclk <= 1'b0;
            if (fin) begin
              fin <= 1'b0;
              flash_cs_n <= 1'b1;
              oe_q <= 1'b1;
              if (nxt == OP_NONE) begin
                st <= ST_DONE;
                done <= 1'b1;
                sram_sel <= 1'b0;
              end else begin
                st <= ST_GAP;
                op <= nxt;
              end
            end else begin
              sh <= {sh[30:0], 1'b0};
              if (op == OP_READ && cyc == 6'd32) oe_q <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qspi_boot_loader_chk.sv
module qspi_boot_loader_chk #(
  parameter int SRAM_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flash_cs_n,
  input logic               flash_sclk,
  input logic [3:0]         flash_io_oe,
  input logic [3:0]         flash_io_out,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               sram_we_n,
  input logic               sram_ce_n,
  input logic               sram_sel,
  input logic               done
);
  logic               seen;
  logic [SRAM_AW-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      prev_addr <= '0;
    end else if (!sram_we_n) begin
      seen <= 1'b1;
      prev_addr <= sram_addr;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sclk);
  assert_single_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_io_oe != 4'b0000 |-> flash_io_oe == 4'b1101 && flash_io_out[3:2] == 2'b11);
  assert_one_clk_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);
  assert_owned_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n && sram_sel);
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && seen) |-> sram_addr == prev_addr + 1'b1);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !sram_sel);
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flash_cs_n && !flash_sclk && sram_we_n);
endmodule

bind qspi_boot_loader qspi_boot_loader_chk #(.SRAM_AW(SRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk),
  .flash_io_oe(flash_io_oe), .flash_io_out(flash_io_out), .sram_addr(sram_addr),
  .sram_we_n(sram_we_n), .sram_ce_n(sram_ce_n), .sram_sel(sram_sel), .done(done)
);

// File: tb/qspi_boot_loader_test.sv
`timescale 1ns/1ps
module qspi_boot_loader_test;
  localparam logic [23:0] FADDR = 24'h001000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] total_bytes = '0;
  logic        flash_cs_n, flash_sclk, sram_we_n, sram_ce_n, sram_sel, done;
  logic [3:0]  flash_io_out, flash_io_oe, flash_io_in;
  logic [9:0]  sram_addr;
  logic [31:0] sram_wdata;

  always #2 clk = ~clk;

  qspi_boot_loader #(.FLASH_ADDR(FADDR)) uut (
    .clk(clk), .rst_n(rst_n), .total_bytes(total_bytes),
    .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk),
    .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we_n(sram_we_n),
    .sram_ce_n(sram_ce_n), .sram_sel(sram_sel), .done(done));

  int checks = 0, failures = 0;

  function automatic logic [7:0] fb(int a);
    return 8'(a * 37 + 11) ^ 8'(a >> 3);
  endfunction

  // behavioural flash and SRAM, sampled 1 ns after each clock edge
  logic       clr_req = 1'b1, qe_cfg = 1'b1;
  int         busy_cfg = 0;
  logic       pcs = 1'b1, psclk = 1'b0;
  logic [7:0] f_op, f_wd, f_sr2, f_first;
  logic [23:0] f_addr;
  int  f_bits, f_busy, f_rdbits, n_rise, n_ops, n_rdsr2, n_wren, n_wrsr, n_rdsr1, n_read;
  int  n_single_bad, n_clash, n_wr, n_badaddr;
  logic       f_qen = 1'b0, f_soen = 1'b0, f_so = 1'b0;
  logic [3:0] f_q = '0;
  logic [31:0] mem [64];

  assign flash_io_in = (!flash_cs_n && f_qen) ? f_q
                     : {2'b00, (!flash_cs_n && f_soen) ? f_so : 1'b0, 1'b0};

  always @(posedge clk) begin
    #1;
    if (clr_req) begin
      f_op = '0; f_wd = '0; f_sr2 = {6'b0, qe_cfg, 1'b0}; f_first = '0; f_addr = '0;
      f_bits = 0; f_busy = 0; f_rdbits = 0; n_rise = 0; n_ops = 0;
      n_rdsr2 = 0; n_wren = 0; n_wrsr = 0; n_rdsr1 = 0; n_read = 0;
      n_single_bad = 0; n_clash = 0; n_wr = 0; n_badaddr = 0;
      f_qen = 1'b0; f_soen = 1'b0; pcs = 1'b1; psclk = 1'b0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
    end else begin
      if (flash_sclk && !psclk) n_rise++;
      if (flash_cs_n && !pcs) begin
        if (f_op == 8'h31 && f_bits >= 16) begin f_sr2 = f_wd; f_busy = busy_cfg; end
        if (f_op == 8'h05 && f_bits >= 16 && f_busy > 0) f_busy--;
        if (f_op == 8'h6B) f_rdbits = f_bits;
        f_qen = 1'b0; f_soen = 1'b0;
      end
      if (!flash_cs_n && pcs) begin f_bits = 0; f_op = '0; end
      if (!flash_cs_n && flash_sclk && !psclk) begin
        if (f_bits < 8) begin
          f_op = {f_op[6:0], flash_io_out[0]};
          if (flash_io_oe != 4'b1101 || flash_io_out[3:2] != 2'b11) n_single_bad++;
        end else if (f_bits < 32) begin
          if (f_op == 8'h31 && f_bits < 16) f_wd = {f_wd[6:0], flash_io_out[0]};
          if (f_op == 8'h6B) f_addr = {f_addr[22:0], flash_io_out[0]};
        end
        f_bits++;
        if (f_bits == 8) begin
          if (n_ops == 0) f_first = f_op;
          n_ops++;
          case (f_op)
            8'h35: n_rdsr2++;
            8'h06: n_wren++;
            8'h31: n_wrsr++;
            8'h05: n_rdsr1++;
            8'h6B: n_read++;
            default: ;
          endcase
        end
      end
      if (!flash_cs_n && !flash_sclk && psclk) begin
        if ((f_op == 8'h35 || f_op == 8'h05) && f_bits >= 8) begin
          logic [7:0] sv;
          sv = (f_op == 8'h35) ? f_sr2 : {7'b0, f_busy > 0};
          f_so = sv[7 - ((f_bits - 8) % 8)];
          f_soen = 1'b1;
        end
        if (f_op == 8'h6B && f_bits >= 40) begin
          logic [7:0] bv;
          bv = fb(int'(f_addr) + (f_bits - 40) / 2);
          f_q = ((f_bits - 40) % 2 == 0) ? bv[7:4] : bv[3:0];
          f_qen = 1'b1;
        end
      end
      if (!flash_cs_n && f_qen && flash_io_oe != 4'b0000) n_clash++;
      if (!flash_cs_n && f_soen && flash_io_oe[1]) n_clash++;
      if (!sram_we_n && !sram_ce_n) begin
        if (sram_addr < 10'd64) mem[sram_addr[5:0]] = sram_wdata; else n_badaddr++;
        n_wr++;
      end
      pcs = flash_cs_n; psclk = flash_sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_case(input int total, input bit qe, input int busy);
    bit ok;
    int nw, rises;
    rst_n = 1'b0;
    total_bytes = 20'(total); qe_cfg = qe; busy_cfg = busy; clr_req = 1'b1;
    repeat (3) @(negedge clk);
    clr_req = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    wait_done(ok);
    chk(ok, "R8", "done reached", ok, 1);
    chk(sram_sel == 1'b0, "R8", "sel released", sram_sel, 0);
    chk(flash_cs_n == 1'b1, "R7", "cs high at end", flash_cs_n, 1);
    chk(f_first == 8'h35, "R1", "first opcode", f_first, 8'h35);
    chk(n_rdsr2 == (qe ? 1 : 2), "R3", "status-2 reads", n_rdsr2, qe ? 1 : 2);
    chk(n_wren == (qe ? 0 : 1) && n_wrsr == n_wren, "R3", "enable writes", n_wren, qe ? 0 : 1);
    chk(n_rdsr1 == (qe ? 0 : busy + 1), "R3", "busy polls", n_rdsr1, qe ? 0 : busy + 1);
    chk(n_single_bad == 0, "R10", "single-line drive", n_single_bad, 0);
    chk(n_clash == 0, "R4", "bus contention", n_clash, 0);
    if (total == 0) begin
      chk(n_read == 0, "R9", "no read command", n_read, 0);
      chk(n_wr == 0, "R9", "no SRAM write", n_wr, 0);
    end else begin
      chk(n_read == 1, "R2", "read commands", n_read, 1);
      chk(f_addr == FADDR, "R2", "read address", f_addr, FADDR);
      chk(f_rdbits == 40 + 2 * total, "R7", "clocks in read", f_rdbits, 40 + 2 * total);
      nw = (total + 3) / 4;
      chk(n_wr == nw && n_badaddr == 0, "R5", "word writes", n_wr, nw);
      for (int i = 0; i < nw; i++) begin
        logic [31:0] exp;
        exp = '0;
        for (int l = 0; l < 4; l++)
          if (i * 4 + l < total) exp[l*8 +: 8] = fb(int'(FADDR) + i * 4 + l);
        if (i == nw - 1 && total % 4 != 0)
          chk(mem[i] == exp, "R6", "partial word", mem[i], exp);
        else
          chk(mem[i] == exp, "R5", "packed word", mem[i], exp);
      end
    end
    rises = n_rise;
    repeat (30) @(negedge clk);
    chk(n_rise == rises, "R7", "no clock after stop", n_rise, rises);
    chk(done == 1'b1, "R8", "done sticky", done, 1);
  endtask

  localparam logic [31:0] VEC [6] = '{
    {16'd16, 8'd1, 8'd0}, {16'd13, 8'd0, 8'd2}, {16'd1, 8'd1, 8'd0},
    {16'd6,  8'd1, 8'd0}, {16'd4,  8'd0, 8'd0}, {16'd9, 8'd1, 8'd1}};

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    chk(flash_cs_n == 1'b1 && flash_sclk == 1'b0, "R1", "idle pins in reset",
        {flash_cs_n, flash_sclk}, 2'b10);
    chk(done == 1'b0 && sram_we_n == 1'b1 && sram_ce_n == 1'b1, "R1", "strobes in reset",
        {done, sram_we_n, sram_ce_n}, 3'b011);
    chk(sram_sel == 1'b1, "R8", "sel owned in reset", sram_sel, 1);
    foreach (VEC[i]) run_case(int'(VEC[i][31:16]), VEC[i][8], int'(VEC[i][7:0]));
    // R9 zero length, with and without the enable routine
    run_case(0, 1'b1, 0);
    run_case(0, 1'b0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule